// File: doc/BRIEF.md
# EEPROM Current Address Pointer

This block keeps the single word-address register that a two-wire serial EEPROM shares between its read and write paths. The bus controller loads it from the word address of a dummy write or a write command. After a completed data byte the controller pulses one of two increment strobes, and the pointer then steps forward. Reads step across the whole array and return to 00h after the top address. Writes step only inside the current 8-byte page, so the page bits never change during a burst.

A current-address read or a sequential read fetches its byte from the pointer as it stands. That value is always one past the last byte that was transferred. A power-on reset or a software reset returns the pointer to 00h. The controller asserts no increment for a byte that a START or STOP cut short, so an aborted byte leaves the pointer unchanged. Every update is registered and appears on the output one clock after its strobe.

Top module: `eeprom_addr_ptr`

## Requirements
- R1: While the asynchronous active-low reset `rst_ni` is low, `cur_addr_o` is 00h.
- R2: A cycle with `soft_rst_i` high sets `cur_addr_o` to 00h on the next clock, whatever the other strobes are.
- R3: A cycle with `load_i` high and `soft_rst_i` low sets `cur_addr_o` to `load_addr_i` on the next clock, and both increment strobes are ignored in that cycle.
- R4: A read increment (`rd_inc_i` high, with no reset, load or write increment in the same cycle) sets `cur_addr_o` to the old value plus one, modulo 256. FFh goes to 00h.
- R5: A write increment (`wr_inc_i` high, with no reset or load in the same cycle) adds one modulo 8 to bits [2:0] of `cur_addr_o` and leaves bits [7:3] unchanged. An address ending in 7h or Fh therefore goes back to the start of its own 8-byte page.
- R6: When `wr_inc_i` and `rd_inc_i` are high together, only the write rule of R5 is applied.
- R7: A cycle with no strobe high leaves `cur_addr_o` unchanged. This is how an aborted byte, for which no strobe is given, leaves the pointer alone.
- R8: After a load of n followed by k read increments, `cur_addr_o` equals (n + k) mod 256, so each sequential-read byte comes from the address already advanced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| soft_rst_i | input | 1 | Software reset strobe; the pointer becomes 00h |
| load_i | input | 1 | Load strobe for a received word address |
| load_addr_i | input | 8 | Word address that is loaded |
| wr_inc_i | input | 1 | Write-byte completion strobe; increments within the page |
| rd_inc_i | input | 1 | Read-byte completion strobe; increments across the whole array |
| cur_addr_o | output | 8 | Current pointer value |

## Verification
On every clock, the assertions check the strobe priority and the three update rules: reset to zero, load, and each of the two wrapping increments, plus holding when no strobe is high. What only the bench scenarios can show is the arithmetic over the whole address range. The bench loads each of the 256 addresses and checks both increments from it, runs multi-byte sequential-read and page-write bursts with their wraps, and checks the asynchronous power-on clear.

// File: rtl/eap_pkg.sv
package eap_pkg;

    localparam int unsigned PTR_W  = 8;
    localparam int unsigned PG_W   = 3;

    // Update chosen for the pointer in one cycle, highest priority first
    typedef enum logic [2:0] {
        OP_HOLD   = 3'd0,
        OP_CLEAR  = 3'd1,
        OP_LOAD   = 3'd2,
        OP_WR_INC = 3'd3,
        OP_RD_INC = 3'd4
    } ptr_op_e;

endpackage

// File: rtl/eap_op_select.sv
module eap_op_select
    import eap_pkg::*;
(
    input  logic    soft_rst_i,
    input  logic    load_i,
    input  logic    wr_inc_i,
    input  logic    rd_inc_i,
    output ptr_op_e op_o
);

    always_comb begin
        if (soft_rst_i)     op_o = OP_CLEAR;
        else if (load_i)    op_o = OP_LOAD;
        else if (wr_inc_i)  op_o = OP_WR_INC;
        else if (rd_inc_i)  op_o = OP_RD_INC;
        else                op_o = OP_HOLD;
    end

endmodule

// File: rtl/eap_wrap_inc.sv
// Adds one to the low WRAP_W bits; the carry does not pass into the bits above.
// When WRAP_W covers the whole word, this is a plain modulo-2^ADDR_W increment.
module eap_wrap_inc #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned WRAP_W = 8
) (
    input  logic [ADDR_W-1:0] cur_i,
    output logic [ADDR_W-1:0] nxt_o
);

    generate
        if (WRAP_W >= ADDR_W) begin : g_full
            assign nxt_o = cur_i + ADDR_W'(1);
        end else begin : g_page
            localparam int unsigned HI_W = ADDR_W - WRAP_W;
            logic [HI_W-1:0]   hi;
            logic [WRAP_W-1:0] lo;
            assign hi    = cur_i[ADDR_W-1:WRAP_W];
            assign lo    = cur_i[WRAP_W-1:0] + WRAP_W'(1);
            assign nxt_o = {hi, lo};
        end
    endgenerate

endmodule

// File: rtl/eeprom_addr_ptr.sv
module eeprom_addr_ptr
    import eap_pkg::*;
#(
    parameter int unsigned ADDR_W = PTR_W,
    parameter int unsigned PAGE_W = PG_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              soft_rst_i,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_addr_i,
    input  logic              wr_inc_i,
    input  logic              rd_inc_i,
    output logic [ADDR_W-1:0] cur_addr_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
    } ptr_state_t;

    ptr_state_t        st_d, st_q;
    ptr_op_e           op;
    logic [ADDR_W-1:0] rd_next, wr_next;

    eap_op_select u_sel (
        .soft_rst_i (soft_rst_i),
        .load_i     (load_i),
        .wr_inc_i   (wr_inc_i),
        .rd_inc_i   (rd_inc_i),
        .op_o       (op)
    );

    // Array-wide wrap used by reads
    eap_wrap_inc #(.ADDR_W(ADDR_W), .WRAP_W(ADDR_W)) u_rd_inc (
        .cur_i (st_q.addr),
        .nxt_o (rd_next)
    );

    // Page-confined wrap used by writes
    eap_wrap_inc #(.ADDR_W(ADDR_W), .WRAP_W(PAGE_W)) u_wr_inc (
        .cur_i (st_q.addr),
        .nxt_o (wr_next)
    );

    always_comb begin
        st_d = st_q;
        unique case (op)
            OP_CLEAR:  st_d.addr = '0;
            OP_LOAD:   st_d.addr = load_addr_i;
            OP_WR_INC: st_d.addr = wr_next;
            OP_RD_INC: st_d.addr = rd_next;
            default:   st_d.addr = st_q.addr;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cur_addr_o = st_q.addr;

endmodule

// File: rtl/eeprom_addr_ptr_chk.sv
module eeprom_addr_ptr_chk #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned PAGE_W = 3
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              soft_rst_i,
    input logic              load_i,
    input logic [ADDR_W-1:0] load_addr_i,
    input logic              wr_inc_i,
    input logic              rd_inc_i,
    input logic [ADDR_W-1:0] cur_addr_o
);

    a_r2_soft_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        soft_rst_i |=> (cur_addr_o == '0));

    a_r3_load_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (load_i && !soft_rst_i) |=> (cur_addr_o == $past(load_addr_i)));

    a_r4_read_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_inc_i && !wr_inc_i && !load_i && !soft_rst_i)
        |=> (cur_addr_o == ADDR_W'($past(cur_addr_o) + ADDR_W'(1))));

    // R5 and R6: the write rule applies whether or not rd_inc_i is also high
    a_r5_page_hi_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_inc_i && !load_i && !soft_rst_i)
        |=> (cur_addr_o[ADDR_W-1:PAGE_W] == $past(cur_addr_o[ADDR_W-1:PAGE_W])));

    a_r6_page_lo_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_inc_i && !load_i && !soft_rst_i)
        |=> (cur_addr_o[PAGE_W-1:0] == PAGE_W'($past(cur_addr_o[PAGE_W-1:0]) + PAGE_W'(1))));

    a_r7_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!wr_inc_i && !rd_inc_i && !load_i && !soft_rst_i) |=> $stable(cur_addr_o));

endmodule

bind eeprom_addr_ptr eeprom_addr_ptr_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (.*);

// File: tb/eeprom_addr_ptr_tb.sv
`timescale 1ns/1ps
module eeprom_addr_ptr_tb;

    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b1;
    logic       soft_rst_i = 1'b0;
    logic       load_i = 1'b0;
    logic [7:0] load_addr_i = '0;
    logic       wr_inc_i = 1'b0;
    logic       rd_inc_i = 1'b0;
    logic [7:0] cur_addr_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk_i = ~clk_i;

    eeprom_addr_ptr u_dut (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .soft_rst_i  (soft_rst_i),
        .load_i      (load_i),
        .load_addr_i (load_addr_i),
        .wr_inc_i    (wr_inc_i),
        .rd_inc_i    (rd_inc_i),
        .cur_addr_o  (cur_addr_o)
    );

    task automatic check(input string req, input logic [7:0] exp);
        checks++;
        if (cur_addr_o !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", req, cur_addr_o, exp);
        end
    endtask

    // Drive strobes at the falling edge, hold across one rising edge, then release
    task automatic cycle(input logic sr, input logic ld, input logic [7:0] la,
                         input logic wi, input logic ri);
        @(negedge clk_i);
        soft_rst_i = sr; load_i = ld; load_addr_i = la; wr_inc_i = wi; rd_inc_i = ri;
        @(posedge clk_i);
        #1;
        soft_rst_i = 1'b0; load_i = 1'b0; wr_inc_i = 1'b0; rd_inc_i = 1'b0;
    endtask

    function automatic logic [7:0] page_step(input logic [7:0] a);
        return {a[7:3], 3'((a[2:0] + 3'd1))};
    endfunction

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #1 rst_ni = 1'b0;
        #9;
        check("R1", 8'h00);
        @(negedge clk_i);
        rst_ni = 1'b1;
        #1;
        check("R1", 8'h00);

        // Exhaustive: every start address, both increment rules
        for (int a = 0; a < 256; a++) begin
            cycle(1'b0, 1'b1, 8'(a), 1'b0, 1'b0);
            check("R3", 8'(a));
            cycle(1'b0, 1'b0, 8'h00, 1'b0, 1'b1);
            check("R4", 8'(a + 1));
            cycle(1'b0, 1'b1, 8'(a), 1'b0, 1'b0);
            cycle(1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
            check("R5", page_step(8'(a)));
            cycle(1'b0, 1'b0, 8'h00, 1'b1, 1'b1);
            check("R6", page_step(page_step(8'(a))));
        end

        // Load wins over both increments
        cycle(1'b0, 1'b1, 8'h5C, 1'b1, 1'b1);
        check("R3", 8'h5C);

        // Idle cycles keep the value (aborted bytes give no strobe)
        for (int i = 0; i < 4; i++) begin
            cycle(1'b0, 1'b0, 8'hAA, 1'b0, 1'b0);
            check("R7", 8'h5C);
        end

        // Sequential read burst across the top of the array
        cycle(1'b0, 1'b1, 8'hFA, 1'b0, 1'b0);
        for (int k = 1; k <= 12; k++) begin
            cycle(1'b0, 1'b0, 8'h00, 1'b0, 1'b1);
            check("R8", 8'(8'hFA + k));
        end

        // Page write burst of ten bytes stays in page 0x48..0x4F
        cycle(1'b0, 1'b1, 8'h4D, 1'b0, 1'b0);
        for (int k = 1; k <= 10; k++) begin
            cycle(1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
            check("R5", {5'b01001, 3'((3'd5 + k) % 8)});
        end

        // Soft reset beats load and increments
        cycle(1'b1, 1'b1, 8'h77, 1'b1, 1'b1);
        check("R2", 8'h00);
        cycle(1'b0, 1'b1, 8'h33, 1'b0, 1'b0);
        cycle(1'b1, 1'b0, 8'h00, 1'b0, 1'b0);
        check("R2", 8'h00);

        // Asynchronous power-on clear mid-run
        cycle(1'b0, 1'b1, 8'h9E, 1'b0, 1'b0);
        @(negedge clk_i);
        #0.5 rst_ni = 1'b0;
        #0.5;
        check("R1", 8'h00);
        @(negedge clk_i);
        rst_ni = 1'b1;
        cycle(1'b0, 1'b0, 8'h00, 1'b0, 1'b1);
        check("R4", 8'h01);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule